// File: doc/BRIEF.md
# PCIe Received Message Dispatcher

This block sits behind the receive-side decoder of a PCIe port. Each accepted message arrives as one beat carrying an 8-bit message code, a 3-bit routing field and a payload word. The port mode input says whether the port is a root port or an endpoint. From the code and the mode, a combinational classifier picks one internal action and decides whether the message goes on to the client. The action can be an INTx level change, a one-cycle error pulse, a slot power limit capture, an LTR capture, an ASPM Nak pulse, an unsupported-request flag, or the start of an automatic PME turn-off acknowledge.

Forwarded messages leave through a valid/ready port backed by a two-place holding stage. The stage is the state machine `fwd_skid`, with states SK_EMPTY, SK_ONE and SK_FULL. Its transitions are:
- take: SK_EMPTY to SK_ONE
- stack: SK_ONE to SK_FULL
- drain: SK_ONE to SK_EMPTY
- swap: SK_ONE to SK_ONE, a push and a pop in the same cycle
- unstack: SK_FULL to SK_ONE

While the stage is in SK_FULL, the input ready is low and the upstream source has to hold its beat.

The automatic acknowledge uses a second state machine, `pme_ack_timer`, with states T_IDLE, T_COUNT and T_ISSUE. Its transitions are:
- arm: any state to T_COUNT, on a qualifying turn-off
- tick: T_COUNT to T_COUNT, while the count is above one
- expire: T_COUNT to T_ISSUE
- finish: T_ISSUE to T_IDLE

Top module: `pcie_msg_dispatch`

## Requirements
- R1: In root-port mode, codes 0x20..0x23 drive `intx_level[code[1:0]]` high and codes 0x24..0x27 drive it low. The change is visible in the cycle after acceptance. The line keeps its level until the opposite message arrives. These messages are not forwarded.
- R2: In root-port mode, codes 0x30, 0x31 and 0x33 raise `err_corr_pulse`, `err_nonfatal_pulse` and `err_fatal_pulse` respectively. The pulse is high only in the cycle after acceptance, and the message is not forwarded.
- R3: Mode gating applies to two groups of codes. INTx and error codes accepted in endpoint mode are dropped with no effect. Codes 0x12, 0x19 and 0x50 accepted in root-port mode are also dropped with no effect.
- R4: In endpoint mode, an OBFF message (0x12) is forwarded when `obff_enable` is 2'b01 or 2'b10. For any other enable value it is not forwarded, and `ur_pulse` is high for the cycle after acceptance.
- R5: In endpoint mode, a PME turn-off message (0x19) arms the automatic acknowledge only when `all_fn_non_d0` is high and `ack_delay` D is nonzero. Such a message is not forwarded. If it is accepted at clock edge k, `pme_ack_req` is high only between edges k+D and k+D+1.
- R6: A PME turn-off message in endpoint mode whose arming condition fails is forwarded and starts no acknowledge.
- R7: A qualifying PME turn-off that arrives while a countdown is running restarts the countdown from the new delay, and only one request results.
- R8: In endpoint mode, code 0x50 loads `slot_pwr_value` from payload bits [7:0] and `slot_pwr_scale` from payload bits [9:8]. The message is not forwarded.
- R9: Code 0x10 captures payload bits [LTR_W-1:0] into `ltr_value` and is not forwarded. `l12_allow` is high only after an LTR has been captured since reset and `ltr_value` >= `l12_threshold`.
- R10: Codes 0x00, 0x01, 0x02, 0x04, 0x05, 0x18, 0x1B, 0x7E and 0x7F are forwarded in either mode with no internal action. Code, routing and payload appear unchanged on the forward port in the cycle after acceptance.
- R11: Code 0x14 is forwarded, and `aspm_nak_pulse` is high for the cycle after acceptance.
- R12: Codes 0x40..0x47, and every code not named in R1 to R11, are dropped with no effect.
- R13: With `fwd_ready` low, two messages can be held, after which `in_ready` is low. Held messages leave in arrival order, and forward outputs stay stable while `fwd_valid` is high and `fwd_ready` is low.
- R14: A synchronous reset clears the INTx levels, the pulses, the pending acknowledge, the captured slot power and LTR state, and the holding stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_is_rp | input | 1 | 1 = root port, 0 = endpoint |
| obff_enable | input | 2 | OBFF enable setting |
| all_fn_non_d0 | input | 1 | Every function is out of D0 |
| ack_delay | input | DLY_W | Automatic acknowledge delay in cycles |
| l12_threshold | input | LTR_W | L1.2 latency threshold |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Input message accepted when high with valid |
| in_code | input | 8 | Message code |
| in_route | input | 3 | Routing field |
| in_data | input | DATA_W | Message payload |
| fwd_valid | output | 1 | Forwarded message valid |
| fwd_ready | input | 1 | Client ready for forwarded message |
| fwd_code | output | 8 | Forwarded message code |
| fwd_route | output | 3 | Forwarded routing field |
| fwd_data | output | DATA_W | Forwarded payload |
| intx_level | output | 4 | INTA..INTD levels (bit 0 = INTA) |
| err_corr_pulse | output | 1 | Correctable error pulse |
| err_nonfatal_pulse | output | 1 | Non-fatal error pulse |
| err_fatal_pulse | output | 1 | Fatal error pulse |
| aspm_nak_pulse | output | 1 | ASPM Nak received pulse |
| ur_pulse | output | 1 | Unsupported OBFF request pulse |
| pme_ack_req | output | 1 | Automatic PME turn-off acknowledge request |
| slot_pwr_scale | output | 2 | Captured slot power scale |
| slot_pwr_value | output | 8 | Captured slot power value |
| ltr_value | output | LTR_W | Captured LTR value |
| l12_allow | output | 1 | L1.2 entry permitted |

## Verification
The assertions assume that the source follows the valid/ready rule, so a beat offered while `in_ready` is low is held and never counted as accepted. They also assume at most one message is accepted per cycle, which is why the three error pulses can be checked for mutual exclusion. The mode, OBFF enable, power-state and delay inputs are taken as static around each acceptance edge. The stimulus changes those inputs only at falling edges, together with the message it applies to, and offers a new beat only on a falling edge after the previous acceptance.

// File: rtl/msg_disp_pkg.sv
package msg_disp_pkg;

    localparam int INT_LINES = 4;
    localparam int SLOT_VAL_W = 8;
    localparam int SLOT_SCL_W = 2;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_INT_SET,
        ACT_INT_CLR,
        ACT_ERR_COR,
        ACT_ERR_NF,
        ACT_ERR_FAT,
        ACT_LTR,
        ACT_SLOT,
        ACT_NAK,
        ACT_PME_AUTO,
        ACT_UR
    } act_e;

    typedef enum logic [1:0] {
        SK_EMPTY,
        SK_ONE,
        SK_FULL
    } skid_state_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_COUNT,
        T_ISSUE
    } timer_state_e;

endpackage

// File: rtl/msg_classify.sv
module msg_classify
    import msg_disp_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic [7:0]       code,
    input  logic             is_rp,
    input  logic [1:0]       obff_en,
    input  logic             all_non_d0,
    input  logic [DLY_W-1:0] delay,
    output act_e             act,
    output logic             fwd
);

    logic obff_ok;
    logic auto_ok;

    assign obff_ok = (obff_en == 2'b01) || (obff_en == 2'b10);
    assign auto_ok = all_non_d0 && (delay != '0);

    always_comb begin
        act = ACT_NONE;
        fwd = 1'b0;
        unique casez (code)
            8'h00, 8'h01, 8'h02, 8'h04, 8'h05,
            8'h18, 8'h1B, 8'h7E, 8'h7F: fwd = 1'b1;
            8'h14: begin
                act = ACT_NAK;
                fwd = 1'b1;
            end
            8'h10: act = ACT_LTR;
            8'b0010_00??: act = is_rp ? ACT_INT_SET : ACT_NONE;
            8'b0010_01??: act = is_rp ? ACT_INT_CLR : ACT_NONE;
            8'h30: act = is_rp ? ACT_ERR_COR : ACT_NONE;
            8'h31: act = is_rp ? ACT_ERR_NF  : ACT_NONE;
            8'h33: act = is_rp ? ACT_ERR_FAT : ACT_NONE;
            8'h50: act = is_rp ? ACT_NONE : ACT_SLOT;
            8'h12: begin
                if (!is_rp) begin
                    if (obff_ok) fwd = 1'b1;
                    else         act = ACT_UR;
                end
            end
            8'h19: begin
                if (!is_rp) begin
                    if (auto_ok) act = ACT_PME_AUTO;
                    else         fwd = 1'b1;
                end
            end
            default: begin
                act = ACT_NONE;
                fwd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/msg_side_fx.sv
module msg_side_fx
    import msg_disp_pkg::*;
#(
    parameter int LTR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   act_v,
    input  act_e                   act,
    input  logic [1:0]             line,
    input  logic [LTR_W-1:0]       data,
    input  logic [LTR_W-1:0]       l12_thresh,
    output logic [INT_LINES-1:0]   intx,
    output logic                   err_cor,
    output logic                   err_nf,
    output logic                   err_fat,
    output logic                   nak,
    output logic                   ur,
    output logic [SLOT_SCL_W-1:0]  slot_scale,
    output logic [SLOT_VAL_W-1:0]  slot_value,
    output logic [LTR_W-1:0]       ltr_val,
    output logic                   l12_allow
);

    localparam int SCL_LO = SLOT_VAL_W;
    localparam int SCL_HI = SLOT_VAL_W + SLOT_SCL_W - 1;

    logic ltr_seen;

    // One level register per interrupt line.
    for (genvar g = 0; g < INT_LINES; g++) begin : g_intx
        always_ff @(posedge clk) begin
            if (rst) begin
                intx[g] <= 1'b0;
            end else if (act_v && (int'(line) == g)) begin
                if (act == ACT_INT_SET)      intx[g] <= 1'b1;
                else if (act == ACT_INT_CLR) intx[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cor <= 1'b0;
            err_nf  <= 1'b0;
            err_fat <= 1'b0;
            nak     <= 1'b0;
            ur      <= 1'b0;
        end else begin
            err_cor <= act_v && (act == ACT_ERR_COR);
            err_nf  <= act_v && (act == ACT_ERR_NF);
            err_fat <= act_v && (act == ACT_ERR_FAT);
            nak     <= act_v && (act == ACT_NAK);
            ur      <= act_v && (act == ACT_UR);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_scale <= '0;
            slot_value <= '0;
            ltr_val    <= '0;
            ltr_seen   <= 1'b0;
        end else if (act_v) begin
            if (act == ACT_SLOT) begin
                slot_value <= data[SLOT_VAL_W-1:0];
                slot_scale <= data[SCL_HI:SCL_LO];
            end
            if (act == ACT_LTR) begin
                ltr_val  <= data;
                ltr_seen <= 1'b1;
            end
        end
    end

    assign l12_allow = ltr_seen && (ltr_val >= l12_thresh);

    // R2: only one message per cycle, so at most one error pulse
    p_err_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_cor, err_nf, err_fat}));

    // R1: levels move only after an accepted INTx message
    p_intx_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !(act_v && (act == ACT_INT_SET || act == ACT_INT_CLR)) |=> $stable(intx));

endmodule

// File: rtl/pme_ack_timer.sv
module pme_ack_timer
    import msg_disp_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] delay,
    output logic             ack_req
);

    timer_state_e state, state_nx;
    logic [DLY_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            T_IDLE:  ;
            T_COUNT: begin
                if (cnt <= 1) state_nx = T_ISSUE;
                else          cnt_nx   = cnt - 1'b1;
            end
            T_ISSUE: state_nx = T_IDLE;
            default: state_nx = T_IDLE;
        endcase
        if (start) begin
            state_nx = T_COUNT;
            cnt_nx   = delay;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= T_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        ack_req = (state == T_ISSUE);
    end

    // R5: a request lasts one cycle
    p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> !ack_req);

    // R7: a fresh start always returns to counting
    p_restart_counts_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == T_COUNT));

endmodule

// File: rtl/fwd_skid.sv
module fwd_skid
    import msg_disp_pkg::*;
#(
    parameter int MSG_W = 43
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [MSG_W-1:0] push_msg,
    output logic             can_take,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [MSG_W-1:0] out_msg
);

    skid_state_e state, state_nx;
    logic [MSG_W-1:0] head_q, spare_q;
    logic pop;

    assign pop = out_valid && out_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            SK_EMPTY: if (push) state_nx = SK_ONE;
            SK_ONE: begin
                if (push && !pop)      state_nx = SK_FULL;
                else if (!push && pop) state_nx = SK_EMPTY;
            end
            SK_FULL:  if (pop) state_nx = SK_ONE;
            default:  state_nx = SK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SK_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            spare_q <= '0;
        end else begin
            unique case (state)
                SK_EMPTY: if (push) head_q <= push_msg;
                SK_ONE: begin
                    if (push && pop)  head_q  <= push_msg;
                    else if (push)    spare_q <= push_msg;
                end
                SK_FULL:  if (pop) head_q <= spare_q;
                default:  ;
            endcase
        end
    end

    always_comb begin
        out_valid = (state != SK_EMPTY);
        out_msg   = head_q;
        can_take  = (state != SK_FULL);
    end

    // R13: a stalled head stays put
    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

    // R13: no push is offered while both places are taken
    p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
        (state == SK_FULL) |-> !push);

endmodule

// File: rtl/pcie_msg_dispatch.sv
module pcie_msg_dispatch
    import msg_disp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LTR_W  = 16,
    parameter int DLY_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 port_is_rp,
    input  logic [1:0]           obff_enable,
    input  logic                 all_fn_non_d0,
    input  logic [DLY_W-1:0]     ack_delay,
    input  logic [LTR_W-1:0]     l12_threshold,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [7:0]           in_code,
    input  logic [2:0]           in_route,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 fwd_valid,
    input  logic                 fwd_ready,
    output logic [7:0]           fwd_code,
    output logic [2:0]           fwd_route,
    output logic [DATA_W-1:0]    fwd_data,
    output logic [3:0]           intx_level,
    output logic                 err_corr_pulse,
    output logic                 err_nonfatal_pulse,
    output logic                 err_fatal_pulse,
    output logic                 aspm_nak_pulse,
    output logic                 ur_pulse,
    output logic                 pme_ack_req,
    output logic [1:0]           slot_pwr_scale,
    output logic [7:0]           slot_pwr_value,
    output logic [LTR_W-1:0]     ltr_value,
    output logic                 l12_allow
);

    localparam int MSG_W = 8 + 3 + DATA_W;

    act_e act;
    logic fwd_sel;
    logic accept;
    logic push;
    logic [MSG_W-1:0] out_msg;

    assign accept = in_valid && in_ready;
    assign push   = accept && fwd_sel;

    msg_classify #(.DLY_W(DLY_W)) u_classify (
        .code       (in_code),
        .is_rp      (port_is_rp),
        .obff_en    (obff_enable),
        .all_non_d0 (all_fn_non_d0),
        .delay      (ack_delay),
        .act        (act),
        .fwd        (fwd_sel)
    );

    msg_side_fx #(.LTR_W(LTR_W)) u_side_fx (
        .clk        (clk),
        .rst        (rst),
        .act_v      (accept),
        .act        (act),
        .line       (in_code[1:0]),
        .data       (in_data[LTR_W-1:0]),
        .l12_thresh (l12_threshold),
        .intx       (intx_level),
        .err_cor    (err_corr_pulse),
        .err_nf     (err_nonfatal_pulse),
        .err_fat    (err_fatal_pulse),
        .nak        (aspm_nak_pulse),
        .ur         (ur_pulse),
        .slot_scale (slot_pwr_scale),
        .slot_value (slot_pwr_value),
        .ltr_val    (ltr_value),
        .l12_allow  (l12_allow)
    );

    pme_ack_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept && (act == ACT_PME_AUTO)),
        .delay   (ack_delay),
        .ack_req (pme_ack_req)
    );

    fwd_skid #(.MSG_W(MSG_W)) u_skid (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_msg  ({in_code, in_route, in_data}),
        .can_take  (in_ready),
        .out_valid (fwd_valid),
        .out_ready (fwd_ready),
        .out_msg   (out_msg)
    );

    assign {fwd_code, fwd_route, fwd_data} = out_msg;

    // R4: a refused OBFF is never also forwarded
    p_ur_no_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        ur_pulse |-> !$past(push));

    // R14: reset leaves every level low
    p_reset_clear_r14: assert property (@(posedge clk)
        $past(rst) |-> (intx_level == '0 && !pme_ack_req && !fwd_valid));

endmodule

// File: tb/pcie_msg_dispatch_tb_top.sv
module pcie_msg_dispatch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int LTR_W  = 16;
    localparam int DLY_W  = 16;

    logic clk = 1'b0;
    logic rst;
    logic port_is_rp;
    logic [1:0] obff_enable;
    logic all_fn_non_d0;
    logic [DLY_W-1:0] ack_delay;
    logic [LTR_W-1:0] l12_threshold;
    logic in_valid;
    logic in_ready;
    logic [7:0] in_code;
    logic [2:0] in_route;
    logic [DATA_W-1:0] in_data;
    logic fwd_valid;
    logic fwd_ready;
    logic [7:0] fwd_code;
    logic [2:0] fwd_route;
    logic [DATA_W-1:0] fwd_data;
    logic [3:0] intx_level;
    logic err_corr_pulse, err_nonfatal_pulse, err_fatal_pulse;
    logic aspm_nak_pulse, ur_pulse, pme_ack_req;
    logic [1:0] slot_pwr_scale;
    logic [7:0] slot_pwr_value;
    logic [LTR_W-1:0] ltr_value;
    logic l12_allow;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcie_msg_dispatch #(.DATA_W(DATA_W), .LTR_W(LTR_W), .DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst(rst), .port_is_rp(port_is_rp), .obff_enable(obff_enable),
        .all_fn_non_d0(all_fn_non_d0), .ack_delay(ack_delay),
        .l12_threshold(l12_threshold), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .in_route(in_route), .in_data(in_data),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_code(fwd_code),
        .fwd_route(fwd_route), .fwd_data(fwd_data), .intx_level(intx_level),
        .err_corr_pulse(err_corr_pulse), .err_nonfatal_pulse(err_nonfatal_pulse),
        .err_fatal_pulse(err_fatal_pulse), .aspm_nak_pulse(aspm_nak_pulse),
        .ur_pulse(ur_pulse), .pme_ack_req(pme_ack_req),
        .slot_pwr_scale(slot_pwr_scale), .slot_pwr_value(slot_pwr_value),
        .ltr_value(ltr_value), .l12_allow(l12_allow)
    );

    typedef struct packed {
        logic [7:0]  code;
        logic [15:0] data;
        logic        rp;
        logic [1:0]  obff;
        logic        fwd;
        logic        ur;
        logic [2:0]  err;   // {fatal, nonfatal, corr}
        logic        nak;
        logic [3:0]  intx;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VECS [NVEC] = '{
        '{8'h20, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0001}, // R1
        '{8'h22, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0101}, // R1
        '{8'h24, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0100}, // R1
        '{8'h21, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0100}, // R3
        '{8'h30, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b001, 1'b0, 4'b0100}, // R2
        '{8'h31, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b010, 1'b0, 4'b0100}, // R2
        '{8'h33, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b100, 1'b0, 4'b0100}, // R2
        '{8'h33, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0100}, // R3
        '{8'h12, 16'h1234, 1'b0, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0100}, // R4
        '{8'h12, 16'h0000, 1'b0, 2'b11, 1'b0, 1'b1, 3'b000, 1'b0, 4'b0100}, // R4
        '{8'h12, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 3'b000, 1'b0, 4'b0100}, // R4
        '{8'h12, 16'h00AA, 1'b0, 2'b10, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0100}, // R4
        '{8'h14, 16'h0055, 1'b1, 2'b00, 1'b1, 1'b0, 3'b000, 1'b1, 4'b0100}, // R11
        '{8'h7E, 16'hBEEF, 1'b0, 2'b00, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0100}, // R10
        '{8'h43, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0100}, // R12
        '{8'h00, 16'h0101, 1'b1, 2'b00, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0100}, // R10
        '{8'h26, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0000}, // R1
        '{8'h19, 16'h0202, 1'b0, 2'b00, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0000}, // R6
        '{8'h19, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0000}, // R3
        '{8'h1B, 16'h0303, 1'b1, 2'b00, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0000}, // R10
        '{8'h05, 16'h0404, 1'b0, 2'b00, 1'b1, 1'b0, 3'b000, 1'b0, 4'b0000}, // R10
        '{8'h99, 16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0000}  // R12
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Offer one beat at a falling edge; it is accepted on the next rising edge.
    task automatic send(input logic [7:0] c, input logic [31:0] d, input logic rp);
        in_code    = c;
        in_data    = d;
        in_route   = 3'b100;
        port_is_rp = rp;
        in_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1'b1;
        port_is_rp = 1'b1;
        obff_enable = 2'b00;
        all_fn_non_d0 = 1'b0;
        ack_delay = '0;
        l12_threshold = '0;
        in_valid = 1'b0;
        in_code = '0;
        in_route = '0;
        in_data = '0;
        fwd_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R14 reset state, R9 no LTR yet
        chk("R14 intx reset", 32'(intx_level), 32'h0);
        chk("R14 fwd_valid reset", 32'(fwd_valid), 32'h0);
        chk("R14 in_ready reset", 32'(in_ready), 32'h1);
        chk("R14 ack reset", 32'(pme_ack_req), 32'h0);
        chk("R9 allow before LTR", 32'(l12_allow), 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            obff_enable = VECS[i].obff;
            send(VECS[i].code, {16'h0, VECS[i].data}, VECS[i].rp);
            chk($sformatf("row %0d fwd_valid", i), 32'(fwd_valid), 32'(VECS[i].fwd));
            if (VECS[i].fwd) begin
                chk($sformatf("row %0d R10 code", i), 32'(fwd_code), 32'(VECS[i].code));
                chk($sformatf("row %0d R10 data", i), fwd_data, {16'h0, VECS[i].data});
                chk($sformatf("row %0d R10 route", i), 32'(fwd_route), 32'h4);
            end
            chk($sformatf("row %0d ur", i), 32'(ur_pulse), 32'(VECS[i].ur));
            chk($sformatf("row %0d err", i),
                32'({err_fatal_pulse, err_nonfatal_pulse, err_corr_pulse}), 32'(VECS[i].err));
            chk($sformatf("row %0d nak", i), 32'(aspm_nak_pulse), 32'(VECS[i].nak));
            chk($sformatf("row %0d intx", i), 32'(intx_level), 32'(VECS[i].intx));
        end
        @(negedge clk);
        chk("R2 pulse gone", 32'({err_fatal_pulse, err_nonfatal_pulse, err_corr_pulse}), 32'h0);

        // R8 slot power capture, then R3 drop in root-port mode
        send(8'h50, 32'h0000_02C7, 1'b0);
        chk("R8 slot value", 32'(slot_pwr_value), 32'hC7);
        chk("R8 slot scale", 32'(slot_pwr_scale), 32'h2);
        chk("R8 not forwarded", 32'(fwd_valid), 32'h0);
        send(8'h50, 32'h0000_0111, 1'b1);
        chk("R3 slot kept", 32'(slot_pwr_value), 32'hC7);

        // R9 LTR capture and compare
        l12_threshold = 16'd50;
        send(8'h10, 32'd100, 1'b1);
        chk("R9 ltr value", 32'(ltr_value), 32'd100);
        chk("R9 allow above", 32'(l12_allow), 32'h1);
        chk("R9 not forwarded", 32'(fwd_valid), 32'h0);
        l12_threshold = 16'd100;
        #1 chk("R9 allow equal", 32'(l12_allow), 32'h1);
        l12_threshold = 16'd200;
        #1 chk("R9 blocked below", 32'(l12_allow), 32'h0);

        // R5 automatic acknowledge, delay 5
        all_fn_non_d0 = 1'b1;
        ack_delay = 16'd5;
        send(8'h19, 32'h0, 1'b0);
        chk("R5 not forwarded", 32'(fwd_valid), 32'h0);
        chk("R5 no early req", 32'(pme_ack_req), 32'h0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R5 req at k=%0d", k), 32'(pme_ack_req), 32'(k == 5));
        end

        // R7 restart while counting
        send(8'h19, 32'h0, 1'b0);
        for (int k = 1; k <= 2; k++) begin
            @(negedge clk);
            chk("R7 quiet before restart", 32'(pme_ack_req), 32'h0);
        end
        send(8'h19, 32'h0, 1'b0);
        chk("R7 quiet at restart", 32'(pme_ack_req), 32'h0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R7 req at k=%0d", k), 32'(pme_ack_req), 32'(k == 5));
        end

        // R6 zero delay goes to the client
        ack_delay = 16'd0;
        send(8'h19, 32'h77, 1'b0);
        chk("R6 zero delay forwarded", 32'(fwd_valid), 32'h1);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R6 no auto req", 32'(pme_ack_req), 32'h0);
        end
        all_fn_non_d0 = 1'b0;

        // R13 back-pressure and ordering
        fwd_ready = 1'b0;
        send(8'h00, 32'd1, 1'b1);
        chk("R13 head valid", 32'(fwd_valid), 32'h1);
        send(8'h01, 32'd2, 1'b1);
        chk("R13 full ready low", 32'(in_ready), 32'h0);
        in_code = 8'h02; in_data = 32'd3; in_valid = 1'b1;
        @(negedge clk);
        chk("R13 head stable", fwd_data, 32'd1);
        fwd_ready = 1'b1;
        @(negedge clk);
        chk("R13 second out", fwd_data, 32'd2);
        chk("R13 ready again", 32'(in_ready), 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R13 third out", fwd_data, 32'd3);
        @(negedge clk);
        chk("R13 drained", 32'(fwd_valid), 32'h0);

        // R14 synchronous reset clears state
        send(8'h23, 32'h0, 1'b1);
        chk("R1 INTD set", 32'(intx_level), 32'h8);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R14 intx cleared", 32'(intx_level), 32'h0);
        chk("R14 slot cleared", 32'(slot_pwr_value), 32'h0);
        chk("R14 ltr cleared", 32'(ltr_value), 32'h0);
        chk("R14 allow cleared", 32'(l12_allow), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule